// File: doc/BRIEF.md
# Triangular Parity Code Min-Sum Decoder

This block is an iterative soft-in soft-out decoder for the triangular single-parity-check code of edge size N = 5. A codeword has 15 bits: 10 data bits and 5 parity bits. Each bit is named by a pair of points drawn from N+1 = 6 points, and each point is one parity check. So every bit is covered by exactly two checks, every check covers exactly N bits, and the Tanner graph has N(N+1) = 30 edges. No two checks share more than one bit, so the graph has no length-4 cycles.

A caller presents all 15 channel LLRs in parallel and pulses `start`. The decoder then runs a fixed number of flooding min-sum iterations, one clock per iteration. It then raises `done` for one cycle and presents three results: the hard-decided data bits, all 15 a-posteriori LLRs for an upstream equalizer to use as extrinsic input, and a flag that is set when every check is satisfied. All results are held until the next accepted start.

Top module: `tspc_minsum_dec`

## Requirements
- R1: After reset, `busy` and `done` are low, every a-posteriori LLR is 0, `data_bits` is 0 and `synd_ok` is 1.
- R2: A `start` sampled while idle captures `llr_in`. `busy` is then high for exactly the next 2 cycles. `done` is high for exactly one cycle, the cycle in which `busy` has just fallen.
- R3: Graph layout. Channel LLR k is at `llr_in[6k+5:6k]`. Bits 0..9 are data bits, numbered in pair order (0,1),(0,2),(0,3),(0,4),(1,2),(1,3),(1,4),(2,3),(2,4),(3,4), where check j covers every data bit whose pair contains j. Bit 10+j is the parity bit shared by check j and check 5. A check-to-bit message has as its sign the XOR of the signs of the other N-1 incoming messages, with zero counted as positive. Its magnitude is the smallest magnitude among those messages.
- R4: A bit-to-check message is the saturated sum of the channel LLR and the message from the bit's other check. Check messages start at zero, so the first iteration sends the channel LLR alone.
- R5: LLRs are 6-bit two's complement and every sum saturates to ±31. An input of -32 is treated as -31. The a-posteriori LLR k, at `post_llr[6k+5:6k]`, is the saturated sum of the channel LLR and both check messages, and it never takes the code -32.
- R6: Bit k is decided as 1 exactly when its a-posteriori LLR is negative, so zero decides to 0. `data_bits[k]` carries the decision for bit k, for k = 0..9.
- R7: `synd_ok` is 1 exactly when each of the 6 checks sees an even number of 1s among the decisions of its bits.
- R8: A `start` sampled while `busy` is high is ignored: neither the captured LLRs nor the result change.
- R9: Between `done` and the next accepted `start`, `post_llr`, `data_bits` and `synd_ok` stay unchanged.
- R10: Each run performs exactly two min-sum iterations. With all channel LLRs at +1, every a-posteriori LLR is +5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode with the LLRs on `llr_in` |
| llr_in | input | 90 | 15 signed 6-bit channel LLRs, bit k at [6k+5:6k] |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| data_bits | output | 10 | Hard decisions of the data bits |
| post_llr | output | 90 | 15 signed 6-bit a-posteriori LLRs |
| synd_ok | output | 1 | All parity checks satisfied |

## Verification
The bench compares every run against a behavioural min-sum model of the graph. It targets single weak errors that only the check messages can correct: a wrong sign product or a wrong second-minimum choice would leave those errors uncorrected or would flip a correct bit. An all-ones input separates exactly two iterations from one (+3) or three (+7). Inputs of -32 and large agreeing LLRs exercise saturation, where a wrapping adder would flip signs. A start pulse during a run, zero LLRs and the hold window after `done` catch a decoder that restarts, decides zero as 1, or lets its outputs drift.

// File: rtl/tspc_pkg.sv
package tspc_pkg;

   typedef enum logic [0:0] {ST_IDLE, ST_RUN} dec_state_e;

   // index of the bit named by point pair (a,b), a < b <= n
   function automatic int pair_idx(input int n, input int a, input int b);
      int base;
      base = 0;
      if (b == n) return n * (n - 1) / 2 + a;
      for (int i = 0; i < a; i++) base += n - 1 - i;
      return base + (b - a - 1);
   endfunction

   // s-th point other than c
   function automatic int other_pt(input int c, input int s);
      return (s < c) ? s : s + 1;
   endfunction

endpackage

// File: rtl/tspc_chk_node.sv
module tspc_chk_node #(
   parameter int DEG = 5,
   parameter int W   = 6
) (
   input  logic signed [W-1:0] msg_in  [DEG],
   output logic signed [W-1:0] msg_out [DEG]
);
   localparam int MW = W - 1;
   localparam int PW = (DEG > 1) ? $clog2(DEG) : 1;

   if (DEG < 2) begin : g_bad_deg
      $error("tspc_chk_node: DEG must be at least 2");
   end

   logic [MW-1:0] mag [DEG];
   logic          sgn_all;
   logic [MW-1:0] min1, min2;
   logic [PW-1:0] pos;

   always_comb begin
      for (int i = 0; i < DEG; i++) begin
         mag[i] = msg_in[i][W-1] ? MW'(-msg_in[i]) : MW'(msg_in[i]);
      end
   end

   // two smallest magnitudes and where the smallest sits
   always_comb begin
      sgn_all = 1'b0;
      min1    = '1;
      min2    = '1;
      pos     = '0;
      for (int i = 0; i < DEG; i++) begin
         sgn_all = sgn_all ^ msg_in[i][W-1];
         if (mag[i] < min1) begin
            min2 = min1;
            min1 = mag[i];
            pos  = PW'(i);
         end else if (mag[i] < min2) begin
            min2 = mag[i];
         end
      end
   end

   always_comb begin
      logic [MW-1:0]       sel;
      logic signed [W-1:0] mo;
      for (int i = 0; i < DEG; i++) begin
         sel        = (PW'(i) == pos) ? min2 : min1;
         mo         = $signed({1'b0, sel});
         msg_out[i] = (sgn_all ^ msg_in[i][W-1]) ? -mo : mo;
      end
   end
endmodule

// File: rtl/tspc_bit_node.sv
module tspc_bit_node #(
   parameter int W = 6
) (
   input  logic signed [W-1:0] ch,
   input  logic signed [W-1:0] m_a,
   input  logic signed [W-1:0] m_b,
   output logic signed [W-1:0] to_a,
   output logic signed [W-1:0] to_b,
   output logic signed [W-1:0] app,
   output logic                hard
);
   localparam logic signed [W+1:0] LIM = (W+2)'(2 ** (W - 1) - 1);

   function automatic logic signed [W-1:0] clip(input logic signed [W+1:0] x);
      if (x > LIM)  return W'(LIM);
      if (x < -LIM) return W'(-LIM);
      return W'(x);
   endfunction

   logic signed [W+1:0] ch_x, a_x, b_x;

   assign ch_x = (W+2)'(ch);
   assign a_x  = (W+2)'(m_a);
   assign b_x  = (W+2)'(m_b);

   assign to_a = clip(ch_x + b_x);
   assign to_b = clip(ch_x + a_x);
   assign app  = clip(ch_x + a_x + b_x);
   assign hard = app[W-1];
endmodule

// File: rtl/tspc_minsum_dec.sv
module tspc_minsum_dec #(
   parameter  int N     = 5,
   parameter  int W     = 6,
   parameter  int ITERS = 2,
   localparam int NB    = N * (N + 1) / 2,
   localparam int K     = N * (N - 1) / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NB*W-1:0] llr_in,
   output logic          busy,
   output logic          done,
   output logic [K-1:0]  data_bits,
   output logic [NB*W-1:0] post_llr,
   output logic          synd_ok
);
   import tspc_pkg::*;

   localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] NEG_LIM  = {1'b1, {(W-2){1'b0}}, 1'b1};

   if (N < 3)     begin : g_bad_n  $error("tspc_minsum_dec: N below 3");     end
   if (W < 3)     begin : g_bad_w  $error("tspc_minsum_dec: W below 3");     end
   if (ITERS < 1) begin : g_bad_it $error("tspc_minsum_dec: ITERS below 1"); end

   dec_state_e          state_q;
   logic [CW-1:0]       iter_q;
   logic signed [W-1:0] ch_q   [NB];
   logic signed [W-1:0] mlo_q  [NB];
   logic signed [W-1:0] mhi_q  [NB];
   logic signed [W-1:0] mlo_d  [NB];
   logic signed [W-1:0] mhi_d  [NB];
   logic signed [W-1:0] b2c_lo [NB];
   logic signed [W-1:0] b2c_hi [NB];
   logic signed [W-1:0] app    [NB];
   logic [NB-1:0]       hard;
   logic [N:0]          chk_par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
         done    <= 1'b0;
         for (int k = 0; k < NB; k++) begin
            ch_q[k]  <= '0;
            mlo_q[k] <= '0;
            mhi_q[k] <= '0;
         end
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_RUN;
               iter_q  <= '0;
               for (int k = 0; k < NB; k++) begin
                  ch_q[k]  <= (llr_in[k*W +: W] == MOST_NEG) ? NEG_LIM : llr_in[k*W +: W];
                  mlo_q[k] <= '0;
                  mhi_q[k] <= '0;
               end
            end
            ST_RUN: begin
               for (int k = 0; k < NB; k++) begin
                  mlo_q[k] <= mlo_d[k];
                  mhi_q[k] <= mhi_d[k];
               end
               if (iter_q == CW'(ITERS - 1)) begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
               end else begin
                  iter_q <= iter_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q == ST_RUN);

   for (genvar k = 0; k < NB; k++) begin : g_bit
      tspc_bit_node #(.W(W)) u_bit (
         .ch   (ch_q[k]),
         .m_a  (mlo_q[k]),
         .m_b  (mhi_q[k]),
         .to_a (b2c_lo[k]),
         .to_b (b2c_hi[k]),
         .app  (app[k]),
         .hard (hard[k])
      );
      assign post_llr[k*W +: W] = app[k];
      if (k < K) begin : g_data
         assign data_bits[k] = hard[k];
      end
   end

   for (genvar c = 0; c <= N; c++) begin : g_chk
      logic signed [W-1:0] cin  [N];
      logic signed [W-1:0] cout [N];
      logic [N-1:0]        hsel;
      for (genvar s = 0; s < N; s++) begin : g_edge
         localparam int O  = other_pt(c, s);
         localparam int LO = (c < O) ? c : O;
         localparam int HI = (c < O) ? O : c;
         localparam int BK = pair_idx(N, LO, HI);
         if (c < O) begin : g_lo
            assign cin[s]    = b2c_lo[BK];
            assign mlo_d[BK] = cout[s];
         end else begin : g_hi
            assign cin[s]    = b2c_hi[BK];
            assign mhi_d[BK] = cout[s];
         end
         assign hsel[s] = hard[BK];
      end
      tspc_chk_node #(.DEG(N), .W(W)) u_node (
         .msg_in  (cin),
         .msg_out (cout)
      );
      assign chk_par[c] = ^hsel;
   end

   assign synd_ok = ~|chk_par;
endmodule

// File: rtl/tspc_minsum_dec_sva.sv
module tspc_minsum_dec_sva #(
   parameter  int N     = 5,
   parameter  int W     = 6,
   parameter  int ITERS = 2,
   localparam int NB    = N * (N + 1) / 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [NB*W-1:0] post_llr
);
   localparam int RW = $clog2(ITERS + 2) + 1;

   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r10_run_length: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == RW'(ITERS)));

   a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < RW'(ITERS)));

   a_r8_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(post_llr));

   for (genvar k = 0; k < NB; k++) begin : g_rng
      a_r5_no_most_neg: assert property (@(posedge clk) disable iff (!rst_n)
         post_llr[k*W +: W] != {1'b1, {(W-1){1'b0}}});
   end
endmodule

bind tspc_minsum_dec tspc_minsum_dec_sva #(.N(N), .W(W), .ITERS(ITERS)) i_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .post_llr (post_llr)
);

// File: tb/test_tspc_minsum_dec.sv
module test_tspc_minsum_dec;
   localparam int N  = 5;
   localparam int W  = 6;
   localparam int NB = 15;
   localparam int K  = 10;

   typedef struct packed {
      logic [K-1:0]    data;
      logic [NB*W-1:0] post;
      logic            ok;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [NB*W-1:0] llr_in = '0;
   logic            busy, done, synd_ok;
   logic [K-1:0]    data_bits;
   logic [NB*W-1:0] post_llr;

   int n_checks = 0;
   int n_fail   = 0;
   exp_t exp_q[$];
   int ca [NB];
   int cb [NB];

   always #4 clk = ~clk;

   tspc_minsum_dec i_tspc_minsum_dec (
      .clk(clk), .rst_n(rst_n), .start(start), .llr_in(llr_in),
      .busy(busy), .done(done), .data_bits(data_bits),
      .post_llr(post_llr), .synd_ok(synd_ok)
   );

   task automatic check(input bit cond, input string req, input string what,
                        input logic [NB*W-1:0] act, input logic [NB*W-1:0] exp);
      n_checks++;
      if (!cond) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int sat(input int x);
      if (x > 31)  return 31;
      if (x < -31) return -31;
      return x;
   endfunction

   function automatic int get_llr(input logic [NB*W-1:0] v, input int k);
      logic signed [W-1:0] t;
      t = v[k*W +: W];
      return sat(int'(t));
   endfunction

   function automatic exp_t model(input logic [NB*W-1:0] v);
      int ch [NB]; int ma [NB]; int mb [NB];
      int qa [NB]; int qb [NB]; int na [NB]; int nb [NB];
      exp_t e;
      for (int k = 0; k < NB; k++) begin
         ch[k] = get_llr(v, k); ma[k] = 0; mb[k] = 0;
      end
      for (int it = 0; it < 2; it++) begin
         for (int k = 0; k < NB; k++) begin
            qa[k] = sat(ch[k] + mb[k]);
            qb[k] = sat(ch[k] + ma[k]);
         end
         for (int k = 0; k < NB; k++) begin
            for (int side = 0; side < 2; side++) begin
               int c; int sg; int mn;
               c = (side == 0) ? ca[k] : cb[k];
               sg = 0; mn = 31;
               for (int j = 0; j < NB; j++) begin
                  if (j != k && (ca[j] == c || cb[j] == c)) begin
                     int val;
                     val = (ca[j] == c) ? qa[j] : qb[j];
                     if (val < 0) begin sg ^= 1; val = -val; end
                     if (val < mn) mn = val;
                  end
               end
               if (side == 0) na[k] = sg ? -mn : mn;
               else           nb[k] = sg ? -mn : mn;
            end
         end
         for (int k = 0; k < NB; k++) begin ma[k] = na[k]; mb[k] = nb[k]; end
      end
      e.ok = 1'b1;
      for (int k = 0; k < NB; k++) begin
         int p;
         p = sat(ch[k] + ma[k] + mb[k]);
         e.post[k*W +: W] = W'(p);
         if (k < K) e.data[k] = (p < 0);
      end
      for (int c = 0; c <= N; c++) begin
         int par; par = 0;
         for (int k = 0; k < NB; k++)
            if ((ca[k] == c || cb[k] == c) && $signed(e.post[k*W +: W]) < 0) par ^= 1;
         if (par != 0) e.ok = 1'b0;
      end
      return e;
   endfunction

   // monitor: pops the scoreboard on every done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "done without pending run", '0, '0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(post_llr == e.post, "R3/R4/R5", "post_llr", post_llr, e.post);
            check(data_bits == e.data, "R6", "data_bits", data_bits, e.data);
            check(synd_ok == e.ok, "R7", "synd_ok", synd_ok, e.ok);
         end
      end
   end

   // driver: one run, with optional second start during busy (R8)
   task automatic run(input logic [NB*W-1:0] v, input bit intrude,
                      input logic [NB*W-1:0] v2);
      @(negedge clk);
      llr_in = v; start = 1'b1;
      exp_q.push_back(model(v));
      @(negedge clk);
      start = intrude; llr_in = intrude ? v2 : v;
      check(busy && !done, "R2", "first busy cycle", {busy, done}, 2'b10);
      @(negedge clk);
      start = 1'b0;
      check(busy && !done, "R2", "second busy cycle", {busy, done}, 2'b10);
      @(negedge clk);
      check(!busy && done, "R10", "done after two iterations", {busy, done}, 2'b01);
      @(negedge clk);
      check(!done, "R2", "done lasts one cycle", done, 1'b0);
   endtask

   function automatic logic [NB*W-1:0] fill(input int val);
      logic [NB*W-1:0] r;
      for (int k = 0; k < NB; k++) r[k*W +: W] = W'(val);
      return r;
   endfunction

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [NB*W-1:0] v;
      logic [NB*W-1:0] held_post;
      logic [K-1:0]    held_data;
      begin
         int k; k = 0;
         for (int a = 0; a < N - 1; a++)
            for (int b = a + 1; b < N; b++) begin ca[k] = a; cb[k] = b; k++; end
         for (int a = 0; a < N; a++) begin ca[K + a] = a; cb[K + a] = N; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 2'b00);
      check(post_llr == '0 && data_bits == '0 && synd_ok, "R1", "outputs after reset",
            post_llr, '0);

      // R10: all +1 gives +5 after exactly two iterations
      run(fill(1), 1'b0, '0);
      check(post_llr == fill(5), "R10", "all +1 posterior", post_llr, fill(5));

      // R5: strong agreement saturates to +31
      run(fill(10), 1'b0, '0);
      check(post_llr == fill(31), "R5", "saturated posterior", post_llr, fill(31));

      // R5: -32 behaves as -31
      run(fill(-32), 1'b0, '0);
      held_post = post_llr;
      run(fill(-31), 1'b0, '0);
      check(post_llr == held_post, "R5", "-32 equals -31", post_llr, held_post);

      // R6: zero LLRs decide to 0
      run(fill(0), 1'b0, '0);
      check(data_bits == '0 && synd_ok, "R6", "zero decides 0", data_bits, '0);

      // R3: one weak error in each bit position, corrected
      for (int e = 0; e < NB; e++) begin
         v = fill(10);
         v[e*W +: W] = W'(-4);
         run(v, 1'b0, '0);
         check(data_bits == '0 && synd_ok, "R3", "weak error corrected",
               {data_bits, synd_ok}, {10'd0, 1'b1});
      end

      // R6/R7: nonzero codewords with a weak error
      for (int t = 0; t < 6; t++) begin
         logic [K-1:0] d;
         logic [NB-1:0] cw;
         d = K'(10'h2A5 * (t + 1) + 13 * t);
         cw = '0;
         for (int k = 0; k < K; k++) cw[k] = d[k];
         for (int j = 0; j < N; j++) begin
            logic p; p = 1'b0;
            for (int k = 0; k < K; k++) if (ca[k] == j || cb[k] == j) p ^= d[k];
            cw[K + j] = p;
         end
         for (int k = 0; k < NB; k++) v[k*W +: W] = cw[k] ? W'(-12) : W'(12);
         v[(t*2)*W +: W] = cw[t*2] ? W'(3) : W'(-3);
         run(v, 1'b0, '0);
         check(data_bits == d, "R6", "codeword data", data_bits, d);
         check(synd_ok, "R7", "codeword syndrome", synd_ok, 1'b1);
      end

      // R8: start during busy is ignored
      v = fill(7);
      v[3*W +: W] = W'(-2);
      run(v, 1'b1, fill(-20));
      check(data_bits == '0, "R8", "intruding start ignored", data_bits, '0);

      // R9: results held while idle
      held_post = post_llr;
      held_data = data_bits;
      repeat (4) @(negedge clk);
      check(post_llr == held_post && data_bits == held_data, "R9", "hold after done",
            post_llr, held_post);

      // pseudo-random vectors through the scoreboard
      void'($urandom(32'h5eed));
      for (int t = 0; t < 40; t++) begin
         for (int k = 0; k < NB; k++) v[k*W +: W] = W'($urandom % 64);
         run(v, 1'b0, '0);
      end

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R2", "all runs completed", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule